// File: doc/BRIEF.md
# DRAM Refresh Cycle Classifier with Row Counter

This block sits beside a dynamic memory array. It samples the active-low row strobe and column strobe on a system clock and works out what kind of cycle each row-strobe assertion starts. It then supplies the row and column addresses for that cycle. The cell array is not part of the block. The block drives only the address paths, a cycle-type code and the data-output enable.

A row strobe that falls while the column strobe is high starts a row-only refresh. The row comes from the external address bus. The column strobe may fall later, which turns the cycle into an ordinary access.

If the column strobe has already been low for a programmable number of clock edges when the row strobe falls, the cycle is a counter refresh. Its row comes from an internal row counter, and the counter then advances. Hidden refresh needs no separate path. It is the case where the column strobe is still held low from a previous read, and the output enable stays on through it.

Inside a counter refresh, the column strobe may rise and then fall again. That sequence opens a counter-test access. The row is the refreshed row with the extra top bit set, and the column is captured on that second fall.

Top module: `dram_cycle_decoder`

## Requirements
- R1: While reset is asserted, and once it is released, cycleType is 0 (idle), outEnable is 0, rowAddr and colAddr are 0, and the row counter restarts at 0.
- R2: A row-strobe fall seen with the column strobe high sets cycleType to 1 (row-only refresh) one clock later and loads rowAddr from addrIn. outEnable stays 0 while the column strobe stays high.
- R3: A column-strobe fall during a type 1 or type 2 cycle sets cycleType to 2 (access), loads colAddr from addrIn and sets outEnable to 1, all one clock later.
- R4: If the column strobe was sampled low on at least SETUP_CYC clock edges before the edge that sees the row strobe fall, cycleType becomes 3 (counter refresh). rowAddr becomes {0, counter}, and the counter then increases by one.
- R5: If the column strobe is low at the row-strobe fall but has led by fewer than SETUP_CYC edges, the cycle is an access (type 2). Both rowAddr and colAddr load from addrIn, and outEnable goes to 1.
- R6: The row counter is ROW_BITS wide and wraps from its maximum value (511 by default) back to 0.
- R7: Hidden refresh keeps the output on. If outEnable is 1 and the column strobe stays low through a row-strobe rise and a qualifying row-strobe fall, outEnable remains 1 and the cycle is a type 3 refresh.
- R8: A column-strobe rise during a type 3 cycle, with the row strobe still low, sets cycleType to 4 (counter test pending).
- R9: The next column-strobe fall in a type 4 cycle sets cycleType to 5 (counter test). Bit ROW_BITS of rowAddr is forced to 1 and the lower bits keep the refreshed row. colAddr loads all address bits from addrIn, and outEnable goes to 1.
- R10: One clock after the row strobe is sampled high, cycleType is 0. rowAddr and colAddr hold their values.
- R11: One clock after the column strobe is sampled high, outEnable is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| addrIn | input | ROW_BITS+1 | Multiplexed external address bus |
| rowAddr | output | ROW_BITS+1 | Row address for the current cycle |
| colAddr | output | ROW_BITS+1 | Column address for the current cycle |
| cycleType | output | 3 | 0 idle, 1 row-only refresh, 2 access, 3 counter refresh, 4 counter test pending, 5 counter test |
| outEnable | output | 1 | Data-output enable; 0 means the output is high impedance |

## Verification
The bench builds the block with ROW_BITS at its default of 9 and SETUP_CYC lowered to 3. With SETUP_CYC at 3, a lead of two edges and a lead of three edges fall on either side of the threshold and can be checked directly. With a 9-bit counter, the 511-to-0 wrap is reached after a few hundred counter-refresh cycles. Hidden refresh and the counter-test entry both run from a known counter value, so the expected rows are exact.

// File: rtl/dcd_pkg.sv
package dcd_pkg;

  typedef enum logic [2:0] {
    CYC_IDLE     = 3'd0,
    CYC_RAS_ONLY = 3'd1,
    CYC_ACCESS   = 3'd2,
    CYC_CBR      = 3'd3,
    CYC_CBR_WAIT = 3'd4,
    CYC_CTEST    = 3'd5
  } cycle_e;

  // strobes from the sequencer to the address datapath
  typedef struct packed {
    logic loadRowExt;
    logic loadRowCnt;
    logic loadCol;
    logic setTopBit;
  } strobe_t;

endpackage

// File: rtl/dcd_control.sv
module dcd_control
  import dcd_pkg::*;
#(
  parameter int SETUP_CYC = 4
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    rasN,
  input  logic    casN,
  output cycle_e  state,
  output logic    outEnable,
  output strobe_t stb
);

  localparam int LEAD_W = $clog2(SETUP_CYC + 1);

  logic rasPrev, casPrev;
  logic [LEAD_W-1:0] leadCnt;
  cycle_e nextState;

  logic rasFall, casFall, casRise, leadOk;

  assign rasFall = !rasN && rasPrev;
  assign casFall = !casN && casPrev;
  assign casRise = casN && !casPrev;
  assign leadOk  = (leadCnt >= LEAD_W'(SETUP_CYC));

  always_comb begin
    nextState = state;
    stb = '0;
    if (rasN) begin
      nextState = CYC_IDLE;
    end else begin
      case (state)
        CYC_IDLE: begin
          if (rasFall) begin
            if (casN) begin
              nextState = CYC_RAS_ONLY;
              stb.loadRowExt = 1'b1;
            end else if (leadOk) begin
              nextState = CYC_CBR;
              stb.loadRowCnt = 1'b1;
            end else begin
              nextState = CYC_ACCESS;
              stb.loadRowExt = 1'b1;
              stb.loadCol = 1'b1;
            end
          end
        end
        CYC_RAS_ONLY, CYC_ACCESS: begin
          if (casFall) begin
            nextState = CYC_ACCESS;
            stb.loadCol = 1'b1;
          end
        end
        CYC_CBR: begin
          if (casRise) nextState = CYC_CBR_WAIT;
        end
        CYC_CBR_WAIT: begin
          if (casFall) begin
            nextState = CYC_CTEST;
            stb.loadCol = 1'b1;
            stb.setTopBit = 1'b1;
          end
        end
        CYC_CTEST: begin
          if (casFall) stb.loadCol = 1'b1;
        end
        default: nextState = CYC_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= CYC_IDLE;
      rasPrev   <= 1'b1;
      casPrev   <= 1'b1;
      leadCnt   <= '0;
      outEnable <= 1'b0;
    end else begin
      state   <= nextState;
      rasPrev <= rasN;
      casPrev <= casN;
      if (casN) leadCnt <= '0;
      else if (!leadOk) leadCnt <= leadCnt + 1'b1;
      if (casN) outEnable <= 1'b0;
      else if (stb.loadCol) outEnable <= 1'b1;
    end
  end

  // R2: row-only cycle keeps the output off
  assert_ronly_hiz_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rasFall && casN) |=> (state == CYC_RAS_ONLY && !outEnable));

  // R10: row strobe high returns to idle
  assert_idle_on_ras_high_R10: assert property (@(posedge clk) disable iff (!rstN)
    rasN |=> (state == CYC_IDLE));

  // R11: column strobe high turns the output off
  assert_oe_drop_R11: assert property (@(posedge clk) disable iff (!rstN)
    casN |=> !outEnable);

  // R9: second column fall in a pending test enters counter test
  assert_ctest_entry_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == CYC_CBR_WAIT && !rasN && casFall) |=> (state == CYC_CTEST && outEnable));

  // R8: column rise during counter refresh arms the test
  assert_ctest_arm_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == CYC_CBR && !rasN && casRise) |=> (state == CYC_CBR_WAIT));

endmodule

// File: rtl/dcd_datapath.sv
module dcd_datapath
  import dcd_pkg::*;
#(
  parameter int ROW_BITS = 9,
  localparam int ADDR_W = ROW_BITS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  strobe_t           stb,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr
);

  logic [ROW_BITS-1:0] refCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt  <= '0;
      rowAddr <= '0;
      colAddr <= '0;
    end else begin
      if (stb.loadRowCnt) begin
        rowAddr <= {1'b0, refCnt};
        refCnt  <= refCnt + ROW_BITS'(1);
      end else if (stb.loadRowExt) begin
        rowAddr <= addrIn;
      end else if (stb.setTopBit) begin
        rowAddr <= {1'b1, rowAddr[ROW_BITS-1:0]};
      end
      if (stb.loadCol) colAddr <= addrIn;
    end
  end

  // R4: counter refresh row comes from the counter, top bit clear
  assert_cbr_row_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadRowCnt |=> (rowAddr == {1'b0, $past(refCnt)}));

  // R9: counter test forces the top row bit and keeps the low bits
  assert_top_bit_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.setTopBit |=> (rowAddr[ADDR_W-1] && rowAddr[ROW_BITS-1:0] == $past(rowAddr[ROW_BITS-1:0])));

endmodule

// File: rtl/dram_cycle_decoder.sv
module dram_cycle_decoder
  import dcd_pkg::*;
#(
  parameter int ROW_BITS = 9,
  parameter int SETUP_CYC = 4,
  localparam int ADDR_W = ROW_BITS + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rasN,
  input  logic              casN,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] rowAddr,
  output logic [ADDR_W-1:0] colAddr,
  output logic [2:0]        cycleType,
  output logic              outEnable
);

  cycle_e  state;
  strobe_t stb;

  dcd_control #(.SETUP_CYC(SETUP_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN),
    .state(state), .outEnable(outEnable), .stb(stb)
  );

  dcd_datapath #(.ROW_BITS(ROW_BITS)) u_path (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .stb(stb),
    .rowAddr(rowAddr), .colAddr(colAddr)
  );

  assign cycleType = state;

endmodule

// File: tb/dram_cycle_decoder_test.sv
module dram_cycle_decoder_test;

  localparam int CLK_PERIOD = 10;
  localparam int ROW_BITS = 9;
  localparam int SETUP = 3;
  localparam int AW = ROW_BITS + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rasN = 1'b1;
  logic casN = 1'b1;
  logic [AW-1:0] addrIn = '0;
  logic [AW-1:0] rowAddr, colAddr;
  logic [2:0] cycleType;
  logic outEnable;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_cycle_decoder #(.ROW_BITS(ROW_BITS), .SETUP_CYC(SETUP)) uut (
    .clk(clk), .rstN(rstN), .rasN(rasN), .casN(casN), .addrIn(addrIn),
    .rowAddr(rowAddr), .colAddr(colAddr), .cycleType(cycleType), .outEnable(outEnable)
  );

  typedef struct packed {
    logic ras;
    logic cas;
    logic [9:0] addr;
    logic [2:0] typ;
    logic oe;
    logic [9:0] row;
    logic [9:0] col;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b1, 10'h000, 3'd0, 1'b0, 10'h000, 10'h000, 4'd10}, // R10 idle
    '{1'b0, 1'b1, 10'h155, 3'd1, 1'b0, 10'h155, 10'h000, 4'd2},  // R2 row-only
    '{1'b0, 1'b1, 10'h3AA, 3'd1, 1'b0, 10'h155, 10'h000, 4'd2},  // R2 row held
    '{1'b0, 1'b0, 10'h0F0, 3'd2, 1'b1, 10'h155, 10'h0F0, 4'd3},  // R3 access
    '{1'b1, 1'b0, 10'h000, 3'd0, 1'b1, 10'h155, 10'h0F0, 4'd10}, // R10 ras up
    '{1'b1, 1'b1, 10'h000, 3'd0, 1'b0, 10'h155, 10'h0F0, 4'd11}, // R11 oe off
    '{1'b1, 1'b0, 10'h000, 3'd0, 1'b0, 10'h155, 10'h0F0, 4'd4},
    '{1'b1, 1'b0, 10'h000, 3'd0, 1'b0, 10'h155, 10'h0F0, 4'd4},
    '{1'b1, 1'b0, 10'h000, 3'd0, 1'b0, 10'h155, 10'h0F0, 4'd4},
    '{1'b0, 1'b0, 10'h2CC, 3'd3, 1'b0, 10'h000, 10'h0F0, 4'd4},  // R4 refresh row 0
    '{1'b0, 1'b1, 10'h000, 3'd4, 1'b0, 10'h000, 10'h0F0, 4'd8},  // R8 armed
    '{1'b0, 1'b0, 10'h123, 3'd5, 1'b1, 10'h200, 10'h123, 4'd9},  // R9 counter test
    '{1'b1, 1'b1, 10'h000, 3'd0, 1'b0, 10'h200, 10'h123, 4'd10}, // R10 hold
    '{1'b1, 1'b0, 10'h000, 3'd0, 1'b0, 10'h200, 10'h123, 4'd5},
    '{1'b1, 1'b0, 10'h000, 3'd0, 1'b0, 10'h200, 10'h123, 4'd5},
    '{1'b0, 1'b0, 10'h077, 3'd2, 1'b1, 10'h077, 10'h077, 4'd5},  // R5 short lead
    '{1'b1, 1'b1, 10'h000, 3'd0, 1'b0, 10'h077, 10'h077, 4'd11}, // R11
    '{1'b0, 1'b1, 10'h010, 3'd1, 1'b0, 10'h010, 10'h077, 4'd2},  // R2 read start
    '{1'b0, 1'b0, 10'h020, 3'd2, 1'b1, 10'h010, 10'h020, 4'd3},  // R3 read
    '{1'b1, 1'b0, 10'h000, 3'd0, 1'b1, 10'h010, 10'h020, 4'd7},  // R7 held
    '{1'b1, 1'b0, 10'h000, 3'd0, 1'b1, 10'h010, 10'h020, 4'd7},  // R7 held
    '{1'b0, 1'b0, 10'h3FF, 3'd3, 1'b1, 10'h001, 10'h020, 4'd7},  // R7 hidden refresh row 1
    '{1'b1, 1'b1, 10'h000, 3'd0, 1'b0, 10'h001, 10'h020, 4'd11}  // R11
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic checkAll(input int req, input string what, input logic [2:0] eTyp,
                          input logic eOe, input logic [AW-1:0] eRow, input logic [AW-1:0] eCol);
    total++;
    if (cycleType !== eTyp || outEnable !== eOe || rowAddr !== eRow || colAddr !== eCol) begin
      bad++;
      $display("FAIL R%0d %s: got type=%0d oe=%0b row=%h col=%h, expected type=%0d oe=%0b row=%h col=%h",
               req, what, cycleType, outEnable, rowAddr, colAddr, eTyp, eOe, eRow, eCol);
    end
  endtask

  task automatic drive(input logic r, input logic c, input logic [AW-1:0] a);
    rasN = r;
    casN = c;
    addrIn = a;
    tick();
  endtask

  initial begin
    int expCnt;
    repeat (3) @(negedge clk);
    checkAll(1, "in reset", 3'd0, 1'b0, '0, '0); // R1
    rstN = 1'b1;
    tick();
    checkAll(1, "after reset", 3'd0, 1'b0, '0, '0); // R1

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].ras, VECS[i].cas, VECS[i].addr);
      checkAll(int'(VECS[i].req), $sformatf("vector %0d", i),
               VECS[i].typ, VECS[i].oe, VECS[i].row, VECS[i].col);
    end

    // R4 and R6: run the counter through its wrap
    expCnt = 2;
    for (int k = 0; k < 511; k++) begin
      drive(1'b1, 1'b0, '0);
      drive(1'b1, 1'b0, '0);
      drive(1'b1, 1'b0, '0);
      drive(1'b0, 1'b0, 10'h155);
      checkAll(expCnt == 0 ? 6 : 4, "counter refresh", 3'd3, 1'b0, {1'b0, 9'(expCnt)}, 10'h020);
      drive(1'b1, 1'b1, '0);
      expCnt = (expCnt + 1) % 512;
    end

    // R1: reset in the middle of a cycle clears state and counter
    drive(1'b0, 1'b1, 10'h2AB);
    checkAll(2, "row-only before reset", 3'd1, 1'b0, 10'h2AB, 10'h020);
    rstN = 1'b0;
    #1;
    checkAll(1, "async reset", 3'd0, 1'b0, '0, '0);
    @(negedge clk);
    rasN = 1'b1;
    rstN = 1'b1;
    tick();
    drive(1'b1, 1'b0, '0);
    drive(1'b1, 1'b0, '0);
    drive(1'b1, 1'b0, '0);
    drive(1'b0, 1'b0, 10'h155);
    checkAll(1, "counter restarted", 3'd3, 1'b0, 10'h000, 10'h000); // R1
    drive(1'b1, 1'b1, '0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule